// File: doc/BRIEF.md
# Dynamic bus sizing transfer sequencer

This block takes one memory request from a processor core and turns it into the external bus cycles needed to carry it. A request names an operand kind (byte, word, long word, or instruction prefetch), a start address, a direction and, for writes, the operand value. The block drives one bus cycle at a time, each with its own address and a code for the bytes still owed. The responding memory reports its port width (8, 16 or 32 bits) in the acknowledge code of that cycle. From that width the block works out how many bytes moved, then moves the address on and issues the next cycle. This repeats until no operand bytes remain.

Port width may differ from one cycle to the next. The number and size of the cycles therefore depend both on how the operand is aligned and on what the memory answers. For writes the block places the next outgoing operand byte on every lane that a narrow port could sample. For reads it collects the incoming bytes into a right-justified result. When the last byte has gone, a one-cycle completion pulse carries the read result and the number of bus cycles used.

Top module: `bus_size_seq`

## Requirements
- R1: A byte request (`req_kind` = 00) completes in exactly one bus cycle for every address offset A[1:0] and every port width.
- R2: A word request (`req_kind` = 01) takes this many bus cycles on 32-, 16- and 8-bit ports: 1/1/2 for offset 00 or 10, 1/2/2 for offset 01, and 2/2/2 for offset 11.
- R3: A long-word request (`req_kind` = 10) takes this many bus cycles on 32-, 16- and 8-bit ports: 1/2/4 for offset 00, 2/3/4 for offset 01 or 11, and 2/2/4 for offset 10. At offset 11 on a 32-bit port, the first cycle moves one byte and the second moves three bytes from the next 4-byte boundary.
- R4: A prefetch request (`req_kind` = 11) ignores the address bits A[1:0]. It moves 4 bytes starting at the 4-byte boundary below the request address, in 1, 2 or 4 cycles on 32-, 16- or 8-bit ports.
- R5: `ack` = 00 means wait. While the block sees it, it holds `cyc_valid`, `cyc_addr`, `cyc_siz` and `cyc_wdata` unchanged. The other `ack` codes report the port width: 01 = 8-bit, 10 = 16-bit, 11 = 32-bit.
- R6: On each acknowledged cycle the bytes moved equal the smaller of two values: the bytes remaining, or the port width minus (address mod port width). The next cycle's address is the current address plus that amount. `cyc_siz` always shows the bytes remaining as 1, 2 or 3, with 4 shown as 00.
- R7: Bus lanes are numbered 0..3 with lane 0 = bits 31:24. A 32-bit port uses lane A[1:0]+i for byte i of a cycle, a 16-bit port uses lane A[0]+i, and an 8-bit port uses lane 0. For writes, `cyc_wdata` carries the operand bytes so that each of these lane choices receives the correct next bytes. The operand is big-endian: its most significant byte goes to the lowest address.
- R8: For reads, each received byte is taken from the lane given in R7 and placed at its big-endian position in the operand. The result is right-justified in `done_rdata` (byte in 7:0, word in 15:0, long word in 31:0) and all other bits are zero.
- R9: One clock after the final acknowledged cycle, `done` is high for exactly one clock and `done_cycles` gives the number of acknowledged bus cycles. `cyc_valid` is low from that clock on.
- R10: A request is taken only when `cyc_valid` is low. A request raised while a transfer is in progress has no effect, and no bus cycle follows the completion unless a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | 00 byte, 01 word, 10 long word, 11 prefetch |
| req_addr | input | AW | Operand start address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write operand, right-justified |
| ack | input | 2 | Per-cycle acknowledge: 00 wait, 01 8-bit, 10 16-bit, 11 32-bit port |
| rdata_in | input | 32 | Read data bus from memory |
| cyc_valid | output | 1 | A bus cycle is being driven |
| cyc_addr | output | AW | Address of the current bus cycle |
| cyc_siz | output | 2 | Bytes remaining (00 = four) |
| cyc_write | output | 1 | Direction of the current cycle |
| cyc_wdata | output | 32 | Write data with lanes placed per R7 |
| done | output | 1 | One-clock completion pulse |
| done_rdata | output | 32 | Assembled read operand, right-justified |
| done_cycles | output | 3 | Bus cycles used by the finished transfer |

## Verification
The bench writes every operand kind at every offset against all three port widths. It compares the cycle counts with the stated table and then reads back a byte-wide memory model. An error in the step rule would show up as a wrong count or as a write that skips or repeats bytes. The worst case is a long word at offset 11, whose second cycle must start exactly on the 4-byte boundary. Reads fill unused lanes with filler, so choosing the wrong lane or the wrong operand position corrupts the result. Further tests apply wait states and check that the bus is held, feed a prefetch at an unaligned address (a design that does not align it fetches the wrong bytes), and raise a new request in mid-transfer (a design that accepts it would reshape the running cycle or start an extra one).

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int CW = $clog2(NB + 1);

  localparam logic [1:0] KIND_BYTE  = 2'b00;
  localparam logic [1:0] KIND_WORD  = 2'b01;
  localparam logic [1:0] KIND_LONG  = 2'b10;
  localparam logic [1:0] KIND_FETCH = 2'b11;

  localparam logic [1:0] ACK_WAIT = 2'b00;
  localparam logic [1:0] ACK_P8   = 2'b01;
  localparam logic [1:0] ACK_P16  = 2'b10;
  localparam logic [1:0] ACK_P32  = 2'b11;

  function automatic logic [2:0] kind_bytes(input logic [1:0] kind);
    case (kind)
      KIND_BYTE: return 3'd1;
      KIND_WORD: return 3'd2;
      default:   return 3'd4;
    endcase
  endfunction

  // Byte m (0 = most significant) of a right-justified operand of tot bytes.
  function automatic logic [7:0] op_byte(input logic [DW-1:0] v,
                                         input logic [2:0] tot,
                                         input logic [2:0] m);
    logic [2:0]    pos;
    logic [DW-1:0] s;
    pos = tot - 3'd1 - m;
    s   = v >> {pos[1:0], 3'b000};
    if (m >= tot) return 8'h00;
    return s[7:0];
  endfunction
endpackage

// File: rtl/bss_step.sv
module bss_step
  import bss_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] ack,
  input  logic [2:0] rem,
  output logic [2:0] nbytes
);
  logic [2:0] room;

  always_comb begin
    case (ack)
      ACK_P8:  room = 3'd1;
      ACK_P16: room = addr_lo[0] ? 3'd1 : 3'd2;
      ACK_P32: room = 3'd4 - {1'b0, addr_lo};
      default: room = 3'd0;
    endcase
    nbytes = (rem < room) ? rem : room;
  end
endmodule

// File: rtl/bss_wr_steer.sv
module bss_wr_steer
  import bss_pkg::*;
(
  input  logic [DW-1:0] wd,
  input  logic [2:0]    tot,
  input  logic [1:0]    k,
  input  logic [1:0]    addr_lo,
  output logic [DW-1:0] bus
);
  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [2:0] rel;
    always_comb begin
      if (2'(j) >= addr_lo)
        rel = 3'(j) - {1'b0, addr_lo};
      else if (addr_lo[1] && (2'(j) >= {1'b0, addr_lo[0]}))
        rel = 3'(j) - {2'b00, addr_lo[0]};
      else
        rel = 3'd0;
    end
    assign bus[8*(NB-1-j) +: 8] = op_byte(wd, tot, {1'b0, k} + rel);
  end
endmodule

// File: rtl/bss_rd_asm.sv
module bss_rd_asm
  import bss_pkg::*;
(
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] bus,
  input  logic [1:0]    addr_lo,
  input  logic [1:0]    ack,
  input  logic [1:0]    k,
  input  logic [2:0]    nbytes,
  input  logic [2:0]    tot,
  output logic [DW-1:0] acc_n
);
  always_comb begin
    acc_n = acc;
    for (int i = 0; i < NB; i++) begin
      logic [1:0]    lane;
      logic [2:0]    m;
      logic [2:0]    pos;
      logic [DW-1:0] bv;
      if (ack == ACK_P32)      lane = addr_lo + 2'(i);
      else if (ack == ACK_P16) lane = {1'b0, addr_lo[0]} + 2'(i);
      else                     lane = 2'd0;
      m   = {1'b0, k} + 3'(i);
      pos = tot - 3'd1 - m;
      bv  = bus >> {2'd3 - lane, 3'b000};
      if ((3'(i) < nbytes) && (m < tot))
        acc_n = acc_n | ({{(DW-8){1'b0}}, bv[7:0]} << {pos[1:0], 3'b000});
    end
  end
endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
  import bss_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    ack,
  input  logic [DW-1:0] rdata_in,
  output logic          cyc_valid,
  output logic [AW-1:0] cyc_addr,
  output logic [1:0]    cyc_siz,
  output logic          cyc_write,
  output logic [DW-1:0] cyc_wdata,
  output logic          done,
  output logic [DW-1:0] done_rdata,
  output logic [CW-1:0] done_cycles
);
  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    rem_q;
  logic [2:0]    tot_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] acc_q;
  logic [CW-1:0] cnt_q;
  logic          write_q;
  logic          done_q;
  logic [DW-1:0] done_rdata_q;
  logic [CW-1:0] done_cnt_q;

  logic          accept;
  logic [AW-1:0] addr_start;
  logic [2:0]    nbytes;
  logic [2:0]    rem_n;
  logic [2:0]    kdiff;
  logic          fire;
  logic          last;
  logic [DW-1:0] acc_rd;
  logic [DW-1:0] acc_n;

  assign accept     = req_valid && !busy_q;
  assign addr_start = (req_kind == KIND_FETCH) ? {req_addr[AW-1:2], 2'b00} : req_addr;
  assign kdiff      = tot_q - rem_q;
  assign rem_n      = rem_q - nbytes;
  assign fire       = busy_q && (nbytes != 3'd0);
  assign last       = fire && (rem_n == 3'd0);
  assign acc_n      = write_q ? acc_q : acc_rd;

  bss_step u_step (
    .addr_lo (addr_q[1:0]),
    .ack     (ack),
    .rem     (rem_q),
    .nbytes  (nbytes)
  );

  bss_wr_steer u_steer (
    .wd      (wd_q),
    .tot     (tot_q),
    .k       (kdiff[1:0]),
    .addr_lo (addr_q[1:0]),
    .bus     (cyc_wdata)
  );

  bss_rd_asm u_asm (
    .acc     (acc_q),
    .bus     (rdata_in),
    .addr_lo (addr_q[1:0]),
    .ack     (ack),
    .k       (kdiff[1:0]),
    .nbytes  (nbytes),
    .tot     (tot_q),
    .acc_n   (acc_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      addr_q       <= '0;
      rem_q        <= 3'd0;
      tot_q        <= 3'd0;
      wd_q         <= '0;
      acc_q        <= '0;
      cnt_q        <= '0;
      write_q      <= 1'b0;
      done_q       <= 1'b0;
      done_rdata_q <= '0;
      done_cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        addr_q  <= addr_start;
        rem_q   <= kind_bytes(req_kind);
        tot_q   <= kind_bytes(req_kind);
        wd_q    <= req_wdata;
        write_q <= req_write;
        acc_q   <= '0;
        cnt_q   <= '0;
      end else if (fire) begin
        addr_q <= addr_q + AW'(nbytes);
        rem_q  <= rem_n;
        acc_q  <= acc_n;
        cnt_q  <= cnt_q + 1'b1;
        if (last) begin
          busy_q       <= 1'b0;
          done_q       <= 1'b1;
          done_rdata_q <= acc_n;
          done_cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cyc_valid   = busy_q;
  assign cyc_addr    = addr_q;
  assign cyc_siz     = rem_q[1:0];
  assign cyc_write   = write_q;
  assign done        = done_q;
  assign done_rdata  = done_rdata_q;
  assign done_cycles = done_cnt_q;
endmodule

// File: rtl/bss_chk.sv
module bss_chk
  import bss_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    req_kind,
  input logic [1:0]    ack,
  input logic          cyc_valid,
  input logic [AW-1:0] cyc_addr,
  input logic [1:0]    cyc_siz,
  input logic [DW-1:0] cyc_wdata,
  input logic          done,
  input logic [CW-1:0] done_cycles
);
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && ack == 2'b00) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_siz) && $stable(cyc_wdata))); // R5

  AST_LAST_BYTE_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_siz == 2'b01 && ack != 2'b00) |=> (!cyc_valid && done)); // R6

  AST_ADDR_MOVES: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && ack != 2'b00) |=> (!cyc_valid || cyc_addr != $past(cyc_addr))); // R6

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cyc_valid && req_kind == 2'b11) |=> (cyc_addr[1:0] == 2'b00 && cyc_siz == 2'b00)); // R4

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(cyc_valid) && $past(ack) != 2'b00 && !cyc_valid)); // R9

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_cycles != '0 && done_cycles <= CW'(NB))); // R9
endmodule

bind bus_size_seq bss_chk #(.AW(AW)) u_chk (.*);

// File: tb/bus_size_seq_tb.sv
`timescale 1ns/1ps
module bus_size_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  ack = 2'b00;
  logic [31:0] rdata_in = '0;
  logic        cyc_valid;
  logic [31:0] cyc_addr;
  logic [1:0]  cyc_siz;
  logic        cyc_write;
  logic [31:0] cyc_wdata;
  logic        done;
  logic [31:0] done_rdata;
  logic [2:0]  done_cycles;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem [0:15];

  always #2 clk = ~clk;

  bus_size_seq #(.AW(32)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .ack(ack), .rdata_in(rdata_in), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
    .cyc_siz(cyc_siz), .cyc_write(cyc_write), .cyc_wdata(cyc_wdata),
    .done(done), .done_rdata(done_rdata), .done_cycles(done_cycles)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes_of(input logic [1:0] kind);
    return (kind == 2'b00) ? 1 : (kind == 2'b01) ? 2 : 4;
  endfunction

  // Stated cycle table; pidx 0 = 32-bit, 1 = 16-bit, 2 = 8-bit port
  function automatic int table_cycles(input logic [1:0] kind, input int off, input int pidx);
    int t [3];
    case (kind)
      2'b00: t = '{1, 1, 1};
      2'b01: begin
        if (off == 0 || off == 2) t = '{1, 1, 2};
        else if (off == 1)        t = '{1, 2, 2};
        else                      t = '{2, 2, 2};
      end
      2'b10: begin
        if (off == 0)      t = '{1, 2, 4};
        else if (off == 2) t = '{2, 2, 4};
        else               t = '{2, 3, 4};
      end
      default: t = '{1, 2, 4};
    endcase
    return t[pidx];
  endfunction

  function automatic logic [1:0] port_code(input int pidx);
    return (pidx == 0) ? 2'b11 : (pidx == 1) ? 2'b10 : 2'b01;
  endfunction

  task automatic fill_mem(input logic [7:0] seed);
    for (int i = 0; i < 16; i++) mem[i] = seed + 8'(i * 37);
  endtask

  task automatic xfer(input logic [1:0] kind, input logic [31:0] addr, input logic wr,
                      input logic [31:0] wd, input logic [1:0] port, input int nwait,
                      input bit poke, output int ncyc, output logic [31:0] rd);
    int          erem, w, p, room, n, lane;
    logic [31:0] ea;
    logic [31:0] bus;
    logic [31:0] snap_a, snap_d;
    logic [1:0]  snap_s;
    bit          held;
    erem = nbytes_of(kind);
    ea   = (kind == 2'b11) ? {addr[31:2], 2'b00} : addr;
    ncyc = 0; w = nwait; held = 0;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_addr = addr; req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc_valid && ncyc < 8) begin
      if (held) begin
        chk(cyc_addr == snap_a && cyc_siz == snap_s && cyc_wdata == snap_d,
            "R5 wait holds cycle", cyc_addr, snap_a);
        held = 0;
      end
      chk(cyc_addr == ea && cyc_siz == 2'(erem) && cyc_write == wr,
          "R6 cycle address/size", {cyc_addr[29:0], cyc_siz}, {ea[29:0], 2'(erem)});
      if (poke && ncyc == 1) begin
        req_valid = 1'b1; req_kind = 2'b00; req_addr = 32'h0000_0041; req_write = ~wr;
      end else begin
        req_valid = 1'b0;
      end
      if (w > 0) begin
        ack = 2'b00; w--; held = 1;
        snap_a = cyc_addr; snap_s = cyc_siz; snap_d = cyc_wdata;
        rdata_in = 32'hEEEE_EEEE;
      end else begin
        ack  = port;
        p    = (port == 2'b01) ? 1 : (port == 2'b10) ? 2 : 4;
        room = p - (int'(ea[1:0]) % p);
        n    = (erem < room) ? erem : room;
        bus  = 32'hEEEE_EEEE;
        for (int i = 0; i < n; i++) begin
          lane = (p == 4) ? int'(ea[1:0]) + i : (p == 2) ? int'(ea[0]) + i : 0;
          if (wr) mem[(ea + 32'(i)) & 32'hF] = cyc_wdata[8*(3-lane) +: 8];
          else    bus[8*(3-lane) +: 8] = mem[(ea + 32'(i)) & 32'hF];
        end
        rdata_in = bus;
        ncyc++;
        ea   = ea + 32'(n);
        erem = erem - n;
      end
      @(negedge clk);
    end
    ack = 2'b00; req_valid = 1'b0;
    chk(done == 1'b1 && cyc_valid == 1'b0, "R9 done after last cycle", {31'b0, done}, 32'd1);
    chk(32'(done_cycles) == 32'(ncyc), "R9 cycle count output", 32'(done_cycles), 32'(ncyc));
    rd = done_rdata;
    @(negedge clk);
    chk(done == 1'b0 && cyc_valid == 1'b0, "R9/R10 single pulse, no extra cycle",
        {30'b0, done, cyc_valid}, 32'd0);
  endtask

  task automatic test_reset();
    chk(cyc_valid == 1'b0 && done == 1'b0 && done_cycles == 3'd0, "reset state",
        {29'b0, cyc_valid, done, 1'b0}, 32'd0);
  endtask

  // R1 R2 R3 R7: writes of every kind, offset and port width
  task automatic test_write_table();
    int          nc;
    logic [31:0] rd, wd, a;
    int          tot;
    string       tg;
    for (int kind = 0; kind < 3; kind++) begin
      for (int off = 0; off < 4; off++) begin
        for (int pi = 0; pi < 3; pi++) begin
          tot = nbytes_of(2'(kind));
          a   = 32'h0000_1230 + 32'(off);
          wd  = 32'hA1B2_C3D4 ^ 32'(kind * 16'h1111 + off * 8'h22 + pi);
          fill_mem(8'h5A);
          xfer(2'(kind), a, 1'b1, wd, port_code(pi), 0, 0, nc, rd);
          tg = (kind == 0) ? "R1 byte cycles" : (kind == 1) ? "R2 word cycles" : "R3 long cycles";
          chk(nc == table_cycles(2'(kind), off, pi), tg, 32'(nc), 32'(table_cycles(2'(kind), off, pi)));
          for (int m = 0; m < tot; m++)
            chk(mem[(a + 32'(m)) & 32'hF] == wd[8*(tot-1-m) +: 8], "R7 write byte lane",
                32'(mem[(a + 32'(m)) & 32'hF]), 32'(wd[8*(tot-1-m) +: 8]));
        end
      end
    end
  endtask

  // R8: read assembly for mixed kinds, offsets and ports
  task automatic test_reads();
    int          nc, tot;
    logic [31:0] rd, a, exp;
    for (int kind = 0; kind < 3; kind++) begin
      for (int off = 0; off < 4; off++) begin
        for (int pi = 0; pi < 3; pi++) begin
          tot = nbytes_of(2'(kind));
          a   = 32'h0000_5670 + 32'(off);
          fill_mem(8'(8'h13 + kind + off));
          exp = '0;
          for (int m = 0; m < tot; m++) exp = (exp << 8) | 32'(mem[(a + 32'(m)) & 32'hF]);
          xfer(2'(kind), a, 1'b0, 32'h0, port_code(pi), 0, 0, nc, rd);
          chk(rd == exp, "R8 read assembled", rd, exp);
        end
      end
    end
  endtask

  // R4: unaligned prefetch is fetched from the long-word boundary
  task automatic test_prefetch();
    int          nc;
    logic [31:0] rd, exp;
    for (int pi = 0; pi < 3; pi++) begin
      fill_mem(8'h71);
      exp = {mem[8], mem[9], mem[10], mem[11]};
      xfer(2'b11, 32'h0000_00AB, 1'b0, 32'h0, port_code(pi), 0, 0, nc, rd);
      chk(nc == table_cycles(2'b11, 0, pi), "R4 prefetch cycles", 32'(nc), 32'(table_cycles(2'b11, 0, pi)));
      chk(rd == exp, "R4 prefetch data from aligned start", rd, exp);
    end
  endtask

  // R5: wait states on a long write through an 8-bit port and a read on 16-bit
  task automatic test_waits();
    int          nc;
    logic [31:0] rd, exp;
    fill_mem(8'h09);
    xfer(2'b10, 32'h0000_2221, 1'b1, 32'hCAFE_F00D, 2'b01, 3, 0, nc, rd);
    chk(nc == 4, "R5 cycles with waits", 32'(nc), 32'd4);
    chk({mem[1], mem[2], mem[3], mem[4]} == 32'hCAFE_F00D, "R5 data after waits",
        {mem[1], mem[2], mem[3], mem[4]}, 32'hCAFE_F00D);
    fill_mem(8'h44);
    exp = {mem[3], mem[4], mem[5], mem[6]};
    xfer(2'b10, 32'h0000_2223, 1'b0, 32'h0, 2'b10, 2, 0, nc, rd);
    chk(rd == exp, "R5 read after waits", rd, exp);
  endtask

  // R10: request during a transfer is ignored
  task automatic test_busy_ignore();
    int          nc;
    logic [31:0] rd;
    fill_mem(8'h00);
    xfer(2'b10, 32'h0000_3332, 1'b1, 32'h1357_9BDF, 2'b01, 0, 1, nc, rd);
    chk(nc == 4, "R10 transfer unchanged by second request", 32'(nc), 32'd4);
    chk({mem[2], mem[3], mem[4], mem[5]} == 32'h1357_9BDF, "R10 data unchanged",
        {mem[2], mem[3], mem[4], mem[5]}, 32'h1357_9BDF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_write_table();
    test_reads();
    test_prefetch();
    test_waits();
    test_busy_ignore();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule